// File: doc/BRIEF.md
# Descriptor-driven I2C transfer sequencer

This block runs a short list of I2C transfers without help from software. The host fills a small descriptor array. Each entry holds a 32-bit control word and a byte count. The host then gives the count of valid entries and pulses a start input. The sequencer walks the entries in index order. It opens each transfer with a start or repeated-start condition and sends the address byte. It then moves the data bytes, and closes the whole list with one stop condition. When the list is done it reports the outcome as a two-bit status.

Bus-level work is handed to an external bit engine through a command stream and a response input. Write data arrives on a byte input stream and read data leaves on a byte output stream. All three streams use valid/ready. A command or an output byte, once offered, stays valid and does not change until the receiver raises ready. The sequencer takes one input byte only when it is about to write it. The bit engine answers every accepted command with exactly one response pulse. The response carries the received byte and a no-acknowledge flag.

The control word holds the address byte in bits 7:0. Bit 0 of that byte is the direction: 1 means read, 0 means write. Three flag bits change the flow:
- bit 31 marks a continuation of the previous transfer;
- bit 30 turns a read into a checksum;
- bit 29 turns on acknowledge polling of the address.

Top module: `i2c_list_seq`

## Requirements
- R1: A start pulse in idle with a nonzero count raises busy until completion. Completion gives a one-cycle done pulse with busy low and the status on the status output (0 ok, 1 no-acknowledge, 2 error). A start pulse while busy is ignored.
- R2: The first descriptor that is not a continuation begins with a START command. Each later one begins with REPEATED START. The list ends with one STOP. Command codes: START 1, REPEATED START 2, STOP 3, WRITE 4, READ 5.
- R3: After the condition, bits 7:0 of the control word are sent as a WRITE command. Bit 0 selects read (1) or write (0) for the data bytes.
- R4: A descriptor with bit 31 set issues no condition and no address byte. It goes straight to its data bytes.
- R5: Each READ command asks for an acknowledge (nack flag 0), except the last byte of a descriptor. That byte carries nack flag 1, unless a next descriptor exists in the list and has bit 31 set.
- R6: Write bytes are taken from the input stream, one per data WRITE command, in order. A no-acknowledge on a data byte ends the list with STOP and status 1.
- R7: A no-acknowledge on the address with bit 29 clear ends the list with STOP and status 1.
- R8: With bit 29 set, a no-acknowledged address is retried with REPEATED START and the address again. At most POLL_LIM address attempts are made, then STOP and status 1.
- R9: A read with bit 30 set sums its bytes modulo 2^SUM_W. The bytes are not sent to the output stream. The sum is readable on the sum output at that descriptor's index.
- R10: A descriptor with zero length sends only its condition and address (if not a continuation) and then moves on.
- R11: A start pulse with a count of zero raises done with status 2. No command is issued and busy stays low.
- R12: A command held without ready keeps its code and byte stable. An output byte held without ready keeps its value stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| go_i | input | 1 | Start the list |
| dsc_cnt_i | input | CNT_W | Number of valid descriptors |
| busy_o | output | 1 | List in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | Outcome of last list |
| dsc_we_i | input | 1 | Descriptor write strobe |
| dsc_idx_i | input | IDX_W | Descriptor index to write |
| dsc_word_i | input | 32 | Control word |
| dsc_len_i | input | LEN_W | Byte count |
| sum_idx_i | input | IDX_W | Checksum read index |
| sum_o | output | SUM_W | Checksum of that descriptor |
| cmd_valid_o | output | 1 | Bus command valid |
| cmd_ready_i | input | 1 | Bit engine accepts command |
| cmd_op_o | output | 3 | Command code |
| cmd_byte_o | output | 8 | Byte to send |
| cmd_nack_o | output | 1 | Read: reply with no-acknowledge |
| rsp_valid_i | input | 1 | Command finished |
| rsp_byte_i | input | 8 | Byte received |
| rsp_nack_i | input | 1 | Write was not acknowledged |
| tx_valid_i | input | 1 | Write byte valid |
| tx_ready_o | output | 1 | Write byte taken |
| tx_data_i | input | 8 | Write byte |
| rx_valid_o | output | 1 | Read byte valid |
| rx_ready_i | input | 1 | Read byte taken |
| rx_data_o | output | 8 | Read byte |

## Verification
Single-descriptor lists are run through plain write, plain read, checksum read and zero length. Next come a data-byte no-acknowledge, an address no-acknowledge without polling, and polling that recovers or runs out. Together these separate the command sequences the flags select. A three-entry list mixes a write, a read and a read continuation. It shows that the second condition is a repeated start and that the continuation skips its address. It also shows that the acknowledge on a read's last byte follows the next entry. Back-pressure on the read stream, a second start pulse during a run, and an empty list check the stream hold rule and the idle-only start.

// File: rtl/i2c_list_seq_pkg.sv
package i2c_list_seq_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_START = 3'd1, OP_RSTART = 3'd2,
    OP_STOP = 3'd3, OP_WRITE = 3'd4, OP_READ = 3'd5
  } bus_op_t;

  typedef enum logic [1:0] {ST_OK = 2'd0, ST_NACK = 2'd1, ST_ERR = 2'd2} seq_status_t;

  typedef enum logic [1:0] {PH_COND, PH_ADDR, PH_DATA, PH_STOP} phase_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_ISSUE, S_WAIT, S_TXGET, S_RXPUT, S_STEP
  } fsm_t;

  // descriptor entry as held internally
  typedef struct packed {
    logic       cont;
    logic       csum;
    logic       poll;
    logic [7:0] addr;
  } dsc_t;
endpackage

// File: rtl/i2c_list_seq_dregs.sv
module i2c_list_seq_dregs
  import i2c_list_seq_pkg::*;
#(
  parameter int N_DESC = 4,
  parameter int LEN_W  = 8,
  parameter int SUM_W  = 16,
  parameter int IDX_W  = (N_DESC > 1) ? $clog2(N_DESC) : 1,
  parameter int CNT_W  = $clog2(N_DESC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [31:0]      wword,
  input  logic [LEN_W-1:0] wlen,
  input  logic [CNT_W-1:0] rd_sel,
  output dsc_t             rd_dsc,
  output logic [LEN_W-1:0] rd_len,
  output dsc_t             nx_dsc,
  input  logic             sum_we,
  input  logic [SUM_W-1:0] sum_val,
  input  logic [IDX_W-1:0] sum_sel,
  output logic [SUM_W-1:0] sum_out
);
  dsc_t             ent  [N_DESC];
  logic [LEN_W-1:0] lens [N_DESC];
  logic [SUM_W-1:0] sums [N_DESC];
  logic [CNT_W-1:0] nsel;
  logic             unused_bits;

  assign unused_bits = ^wword[28:8];
  assign nsel = rd_sel + CNT_W'(1);

  for (genvar g = 0; g < N_DESC; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent[g]  <= '0;
        lens[g] <= '0;
        sums[g] <= '0;
      end else begin
        if (we && widx == IDX_W'(g)) begin
          ent[g]  <= '{cont: wword[31], csum: wword[30], poll: wword[29], addr: wword[7:0]};
          lens[g] <= wlen;
        end
        if (sum_we && rd_sel == CNT_W'(g)) sums[g] <= sum_val;
      end
    end
  end

  always_comb begin
    rd_dsc = '0;
    rd_len = '0;
    nx_dsc = '0;
    if (rd_sel < CNT_W'(N_DESC)) begin
      rd_dsc = ent[rd_sel[IDX_W-1:0]];
      rd_len = lens[rd_sel[IDX_W-1:0]];
    end
    if (nsel < CNT_W'(N_DESC)) nx_dsc = ent[nsel[IDX_W-1:0]];
  end

  assign sum_out = sums[sum_sel];
endmodule

// File: rtl/i2c_list_seq_sumacc.sv
module i2c_list_seq_sumacc #(
  parameter int SUM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add,
  input  logic [7:0]       byte_i,
  output logic [SUM_W-1:0] acc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_o <= '0;
    else if (clr) acc_o <= '0;
    else if (add) acc_o <= acc_o + SUM_W'(byte_i);
  end
endmodule

// File: rtl/i2c_list_seq.sv
module i2c_list_seq
  import i2c_list_seq_pkg::*;
#(
  parameter int N_DESC   = 4,
  parameter int LEN_W    = 8,
  parameter int SUM_W    = 16,
  parameter int POLL_LIM = 150,
  parameter int IDX_W    = (N_DESC > 1) ? $clog2(N_DESC) : 1,
  parameter int CNT_W    = $clog2(N_DESC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [CNT_W-1:0] dsc_cnt_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       status_o,
  input  logic             dsc_we_i,
  input  logic [IDX_W-1:0] dsc_idx_i,
  input  logic [31:0]      dsc_word_i,
  input  logic [LEN_W-1:0] dsc_len_i,
  input  logic [IDX_W-1:0] sum_idx_i,
  output logic [SUM_W-1:0] sum_o,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic [2:0]       cmd_op_o,
  output logic [7:0]       cmd_byte_o,
  output logic             cmd_nack_o,
  input  logic             rsp_valid_i,
  input  logic [7:0]       rsp_byte_i,
  input  logic             rsp_nack_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  input  logic [7:0]       tx_data_i,
  output logic             rx_valid_o,
  input  logic             rx_ready_i,
  output logic [7:0]       rx_data_o
);
  localparam int TRY_W = $clog2(POLL_LIM + 1);

  fsm_t             state;
  phase_t           phase;
  bus_op_t          op_r;
  seq_status_t      stat_r;
  logic [CNT_W-1:0] idx, cnt;
  logic [LEN_W-1:0] cur_len;
  logic [TRY_W-1:0] tries;
  logic [7:0]       byte_r, rx_r;
  logic             nack_r, first, done_r;
  dsc_t             cur, nxt;
  logic [LEN_W-1:0] ld_len;
  logic [SUM_W-1:0] acc;
  logic             is_read, nx_cont, sum_add, sum_clr, sum_we;

  i2c_list_seq_dregs #(.N_DESC(N_DESC), .LEN_W(LEN_W), .SUM_W(SUM_W),
                       .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dregs (
    .clk(clk), .rst_n(rst_n), .we(dsc_we_i), .widx(dsc_idx_i),
    .wword(dsc_word_i), .wlen(dsc_len_i), .rd_sel(idx), .rd_dsc(cur),
    .rd_len(ld_len), .nx_dsc(nxt), .sum_we(sum_we), .sum_val(acc),
    .sum_sel(sum_idx_i), .sum_out(sum_o));

  i2c_list_seq_sumacc #(.SUM_W(SUM_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .clr(sum_clr), .add(sum_add),
    .byte_i(rsp_byte_i), .acc_o(acc));

  assign is_read = cur.addr[0];
  assign nx_cont = ({1'b0, idx} + (CNT_W+1)'(1) < {1'b0, cnt}) && nxt.cont;
  assign sum_clr = (state == S_LOAD);
  assign sum_add = (state == S_WAIT) && rsp_valid_i && (phase == PH_DATA) && is_read && cur.csum;
  assign sum_we  = (state == S_STEP) && (cur_len == '0) && is_read && cur.csum;

  assign busy_o      = (state != S_IDLE);
  assign done_o      = done_r;
  assign status_o    = stat_r;
  assign cmd_valid_o = (state == S_ISSUE);
  assign cmd_op_o    = op_r;
  assign cmd_byte_o  = byte_r;
  assign cmd_nack_o  = nack_r;
  assign tx_ready_o  = (state == S_TXGET);
  assign rx_valid_o  = (state == S_RXPUT);
  assign rx_data_o   = rx_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  phase <= PH_COND; op_r <= OP_NONE; stat_r <= ST_OK;
      idx <= '0; cnt <= '0; cur_len <= '0; tries <= '0;
      byte_r <= '0; rx_r <= '0; nack_r <= 1'b0; first <= 1'b1; done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      unique case (state)
        S_IDLE: if (go_i) begin
          if (dsc_cnt_i == '0) begin
            stat_r <= ST_ERR;
            done_r <= 1'b1;
          end else begin
            cnt <= dsc_cnt_i; idx <= '0; first <= 1'b1;
            stat_r <= ST_OK; state <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (idx == cnt) begin
            phase <= PH_STOP; op_r <= OP_STOP; state <= S_ISSUE;
          end else begin
            cur_len <= ld_len;
            if (cur.cont) begin
              phase <= PH_DATA; state <= S_STEP;
            end else begin
              phase <= PH_COND; op_r <= first ? OP_START : OP_RSTART;
              first <= 1'b0; tries <= TRY_W'(1); state <= S_ISSUE;
            end
          end
        end
        S_ISSUE: if (cmd_ready_i) state <= S_WAIT;
        S_WAIT: if (rsp_valid_i) begin
          unique case (phase)
            PH_COND: begin
              phase <= PH_ADDR; op_r <= OP_WRITE; byte_r <= cur.addr;
              nack_r <= 1'b0; state <= S_ISSUE;
            end
            PH_ADDR: begin
              if (!rsp_nack_i) begin
                phase <= PH_DATA; state <= S_STEP;
              end else if (cur.poll && tries < TRY_W'(POLL_LIM)) begin
                tries <= tries + TRY_W'(1); phase <= PH_COND;
                op_r <= OP_RSTART; state <= S_ISSUE;
              end else begin
                stat_r <= ST_NACK; phase <= PH_STOP; op_r <= OP_STOP; state <= S_ISSUE;
              end
            end
            PH_DATA: begin
              cur_len <= cur_len - LEN_W'(1);
              if (!is_read && rsp_nack_i) begin
                stat_r <= ST_NACK; phase <= PH_STOP; op_r <= OP_STOP; state <= S_ISSUE;
              end else if (is_read && !cur.csum) begin
                rx_r <= rsp_byte_i; state <= S_RXPUT;
              end else begin
                state <= S_STEP;
              end
            end
            default: begin
              done_r <= 1'b1; state <= S_IDLE;
            end
          endcase
        end
        S_TXGET: if (tx_valid_i) begin
          byte_r <= tx_data_i; op_r <= OP_WRITE; nack_r <= 1'b0; state <= S_ISSUE;
        end
        S_RXPUT: if (rx_ready_i) state <= S_STEP;
        default: begin
          if (cur_len == '0) begin
            idx <= idx + CNT_W'(1); state <= S_LOAD;
          end else if (is_read) begin
            op_r <= OP_READ; nack_r <= (cur_len == LEN_W'(1)) && !nx_cont;
            state <= S_ISSUE;
          end else begin
            state <= S_TXGET;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_list_seq_chk.sv
module i2c_list_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] status_o,
  input logic       cmd_valid_o,
  input logic       cmd_ready_i,
  input logic [2:0] cmd_op_o,
  input logic [7:0] cmd_byte_o,
  input logic       tx_ready_o,
  input logic       rx_valid_o,
  input logic       rx_ready_i,
  input logic [7:0] rx_data_o
);
  p_cmd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_byte_o));

  p_rx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o && !rx_ready_i |=> rx_valid_o && $stable(rx_data_o));

  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_busy_from_go_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(go_i));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !cmd_valid_o && !rx_valid_o && !tx_ready_o);

  p_status_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> status_o != 2'd3);

  p_empty_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !$past(busy_o) |-> status_o == 2'd2);
endmodule

bind i2c_list_seq i2c_list_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go_i(go_i), .busy_o(busy_o), .done_o(done_o),
  .status_o(status_o), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
  .cmd_op_o(cmd_op_o), .cmd_byte_o(cmd_byte_o), .tx_ready_o(tx_ready_o),
  .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i), .rx_data_o(rx_data_o));

// File: tb/i2c_list_seq_test.sv
module i2c_list_seq_test;
  localparam int CLK_NS = 10;

  typedef struct packed {
    logic [31:0] word;
    logic [7:0]  len;
    logic [7:0]  anack;
    logic [7:0]  wnack;
    logic [1:0]  st;
    logic [7:0]  ncmd;
    logic [7:0]  nrx;
    logic [15:0] sum;
  } vec_t;

  localparam vec_t VEC [8] = '{
    {32'h000000A0, 8'd2, 8'd0,   8'hFF, 2'd0, 8'd5, 8'd0, 16'h0000},
    {32'h000000A1, 8'd3, 8'd0,   8'hFF, 2'd0, 8'd6, 8'd3, 16'h0000},
    {32'h400000A1, 8'd3, 8'd0,   8'hFF, 2'd0, 8'd6, 8'd0, 16'h0093},
    {32'h000000A0, 8'd0, 8'd0,   8'hFF, 2'd0, 8'd3, 8'd0, 16'h0000},
    {32'h000000A0, 8'd3, 8'd0,   8'd1,  2'd1, 8'd5, 8'd0, 16'h0000},
    {32'h000000A0, 8'd1, 8'd1,   8'hFF, 2'd1, 8'd3, 8'd0, 16'h0000},
    {32'h200000A0, 8'd0, 8'd2,   8'hFF, 2'd0, 8'd7, 8'd0, 16'h0000},
    {32'h200000A0, 8'd0, 8'd255, 8'hFF, 2'd1, 8'd9, 8'd0, 16'h0000}
  };
  localparam string VREQ [8] = '{"R6", "R5", "R9", "R10", "R6", "R7", "R8", "R8"};

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic [2:0] dsc_cnt = '0;
  logic busy, done, cmd_valid, cmd_nack, tx_ready, rx_valid;
  logic [1:0] status;
  logic dsc_we = 1'b0;
  logic [1:0] dsc_idx = '0, sum_idx = '0;
  logic [31:0] dsc_word = '0;
  logic [7:0] dsc_len = '0, cmd_byte, rx_data, tx_data;
  logic [15:0] sum;
  logic [2:0] cmd_op;
  logic cmd_ready = 1'b1, tx_valid = 1'b1, rx_ready = 1'b1;
  logic rsp_valid = 1'b0, rsp_nack = 1'b0;
  logic [7:0] rsp_byte = '0;
  logic clr = 1'b1;
  int a_lim = 0, w_at = 255;
  int n_log, n_rx, n_done, rd_cnt, wr_cnt, a_cnt, tx_cnt;
  logic prev_cond;
  logic [2:0] log_op [32];
  logic [7:0] log_byte [32];
  logic       log_nack [32];
  logic [7:0] rx_log [32];
  int n_checks = 0, n_err = 0;

  always #(CLK_NS/2) clk = ~clk;
  assign tx_data = 8'h50 + 8'(tx_cnt);

  i2c_list_seq #(.N_DESC(4), .LEN_W(8), .SUM_W(16), .POLL_LIM(4)) uut (
    .clk(clk), .rst_n(rst_n), .go_i(go), .dsc_cnt_i(dsc_cnt), .busy_o(busy),
    .done_o(done), .status_o(status), .dsc_we_i(dsc_we), .dsc_idx_i(dsc_idx),
    .dsc_word_i(dsc_word), .dsc_len_i(dsc_len), .sum_idx_i(sum_idx), .sum_o(sum),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_op_o(cmd_op),
    .cmd_byte_o(cmd_byte), .cmd_nack_o(cmd_nack), .rsp_valid_i(rsp_valid),
    .rsp_byte_i(rsp_byte), .rsp_nack_i(rsp_nack), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .tx_data_i(tx_data), .rx_valid_o(rx_valid),
    .rx_ready_i(rx_ready), .rx_data_o(rx_data));

  // bit-engine and stream model
  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (clr) begin
      n_log <= 0; n_rx <= 0; n_done <= 0; rd_cnt <= 0; wr_cnt <= 0;
      a_cnt <= 0; tx_cnt <= 0; prev_cond <= 1'b0;
    end else begin
      if (done) n_done <= n_done + 1;
      if (tx_valid && tx_ready) tx_cnt <= tx_cnt + 1;
      if (rx_valid && rx_ready && n_rx < 32) begin
        rx_log[n_rx] <= rx_data; n_rx <= n_rx + 1;
      end
      if (cmd_valid && cmd_ready) begin
        if (n_log < 32) begin
          log_op[n_log] <= cmd_op; log_byte[n_log] <= cmd_byte; log_nack[n_log] <= cmd_nack;
        end
        n_log <= n_log + 1;
        rsp_valid <= 1'b1; rsp_nack <= 1'b0; rsp_byte <= 8'h00;
        if (cmd_op == 3'd4) begin
          if (prev_cond) begin
            rsp_nack <= (a_cnt < a_lim); a_cnt <= a_cnt + 1;
          end else begin
            rsp_nack <= (wr_cnt == w_at); wr_cnt <= wr_cnt + 1;
          end
        end else if (cmd_op == 3'd5) begin
          rsp_byte <= 8'h30 + 8'(rd_cnt); rd_cnt <= rd_cnt + 1;
        end
        prev_cond <= (cmd_op == 3'd1) || (cmd_op == 3'd2);
      end
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic wdesc(input int i, input logic [31:0] w, input logic [7:0] l);
    @(negedge clk);
    dsc_we = 1'b1; dsc_idx = 2'(i); dsc_word = w; dsc_len = l;
    @(negedge clk);
    dsc_we = 1'b0;
  endtask

  task automatic reset_log(input int alim, input int wat);
    @(negedge clk);
    clr = 1'b1; a_lim = alim; w_at = wat;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic kick(input int c);
    @(negedge clk);
    dsc_cnt = 3'(c); go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 20000; k++) begin
      if (done) return;
      @(negedge clk);
    end
    chk("R1 watchdog", 0, 1);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_err++;
    $display("FAIL R1 global watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset busy", 32'(busy), 0);
    chk("R1 reset done", 32'(done), 0);
    chk("R12 reset cmd_valid", 32'(cmd_valid), 0);
    chk("R1 reset status", 32'(status), 0);

    // table of single-descriptor lists
    for (int v = 0; v < 8; v++) begin
      reset_log(int'(VEC[v].anack), int'(VEC[v].wnack));
      wdesc(0, VEC[v].word, VEC[v].len);
      kick(1);
      wait_done();
      chk({VREQ[v], " status"}, 32'(status), 32'(VEC[v].st));
      @(negedge clk);
      chk({VREQ[v], " command count"}, n_log, 32'(VEC[v].ncmd));
      chk({VREQ[v], " rx count"}, n_rx, 32'(VEC[v].nrx));
      chk("R2 first is START", 32'(log_op[0]), 1);
      chk("R2 last is STOP", 32'(log_op[n_log-1]), 3);
      chk("R3 address byte", 32'(log_byte[1]), VEC[v].word & 32'hFF);
      if (VEC[v].word[30]) chk("R9 checksum", 32'(sum), 32'(VEC[v].sum));
      if (v == 0) chk("R6 second data byte", 32'(log_byte[3]), 32'h51);
      if (v == 1) begin
        chk("R5 first read acked", 32'(log_nack[2]), 0);
        chk("R5 last read not acked", 32'(log_nack[4]), 1);
        chk("R5 rx byte order", 32'(rx_log[2]), 32'h32);
      end
      if (v == 6) chk("R8 retry uses REPEATED START", 32'(log_op[2]), 2);
    end

    // three-entry list with continuation and read back-pressure
    reset_log(0, 255);
    wdesc(0, 32'h000000A0, 8'd1);
    wdesc(1, 32'h000000A1, 8'd2);
    wdesc(2, 32'h80000001, 8'd1);
    rx_ready = 1'b0;
    kick(3);
    for (int k = 0; k < 200 && !rx_valid; k++) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R12 rx held valid", 32'(rx_valid), 1);
    chk("R12 rx held data", 32'(rx_data), 32'h30);
    chk("R1 busy during run", 32'(busy), 1);
    go = 1'b1; dsc_cnt = 3'd1;
    @(negedge clk);
    go = 1'b0;
    rx_ready = 1'b1;
    wait_done();
    chk("R1 multi status", 32'(status), 0);
    repeat (4) @(negedge clk);
    chk("R1 second go ignored: one done", n_done, 1);
    chk("R4 command count", n_log, 9);
    chk("R6 write data byte", 32'(log_byte[2]), 32'h50);
    chk("R2 second condition REPEATED START", 32'(log_op[3]), 2);
    chk("R4 continuation goes straight to READ", 32'(log_op[7]), 5);
    chk("R5 ack before continuation", 32'(log_nack[6]), 0);
    chk("R5 final read not acked", 32'(log_nack[7]), 1);
    chk("R2 final STOP", 32'(log_op[8]), 3);
    chk("R4 rx third byte", 32'(rx_log[2]), 32'h32);

    // empty list
    reset_log(0, 255);
    kick(0);
    wait_done();
    chk("R11 status error", 32'(status), 2);
    chk("R11 busy low", 32'(busy), 0);
    @(negedge clk);
    chk("R11 no commands", n_log, 0);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule